// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Node

This block is the coherence controller of one node on a shared bus. It holds a small direct-mapped cache of four single-word lines. Each line has a tag, a data word and three state bits: valid, dirty and shared. The controller serves one request at a time from its own processor. It also watches every transaction that other nodes place on the bus.

Before a local write completes, the controller makes the node the only holder of the block. It fetches the block with a read-for-ownership, or it broadcasts an invalidate when it already holds a shared copy. A dirty line that must leave the cache is first written back to memory. When another node reads a block this cache holds dirty, the controller drives its own copy onto the bus and tells memory not to answer. When another node claims ownership of a block, the controller drops its own copy.

The bus carries one transaction per cycle. A transaction completes in the cycle where this node's request and the grant are both high. Read data is taken from the bus in that same cycle. The environment never grants this node in a cycle that carries another node's transaction.

Top module: `snoop_inval_cache`

## Requirements
- R1: A 6-bit processor address splits into a 4-bit tag (bits 5:2) and a 2-bit line index (bits 1:0). An access hits when the indexed line is valid and its tag equals the address tag. A read hit, or a write hit on a valid line whose shared bit is clear, raises the ready signal in the cycle after the request is taken, with no bus request. A write hit of that kind sets dirty.
- R2: During reset and right after it, every line is empty: valid, dirty and shared are all 0. Ready, the bus request and data supply are all low.
- R3: A read miss to a clean or invalid line requests a bus read (op code 00) at the request address. When granted, the line takes the bus data and ends with valid=1, dirty=0, shared=1.
- R4: A write miss requests a read-for-ownership (op code 01) at the request address. When granted, the line holds the write data and ends with valid=1, dirty=1, shared=0.
- R5: A write hit on a line whose shared bit is set first requests an invalidate (op code 10) at the request address. After the grant, the line holds the write data with dirty=1 and shared=0.
- R6: A miss whose line is valid and dirty first requests a writeback (op code 11). The writeback address is the stored tag followed by the index, and it carries the line's data. The fetch is requested only after that grant.
- R7: A snooped read (00) or read-for-ownership (01) that hits a dirty line raises data-supply and memory-cancel in the same cycle and drives the line's data. After a snooped read, the line is clean (dirty=0) and shared=1. A snooped read that hits a clean line sets shared and supplies nothing.
- R8: A snooped read-for-ownership or invalidate (10) that hits a line clears its valid, dirty and shared bits. A snooped writeback (11), or any snoop whose tag differs or whose line is invalid, leaves the line unchanged.
- R9: Two writers of the same block are ordered by the grant. If a snooped read-for-ownership or invalidate removes the line while this node waits for its own invalidate grant, the controller drops the invalidate and requests a read-for-ownership instead.
- R10: Ready is a single-cycle pulse. It stays low until every bus transaction the access needs has been granted. A processor request that arrives in a cycle carrying a snooped transaction is taken one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 6 | Processor address: tag in bits 5:2, index in bits 1:0 |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Line data, valid while ready is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Request for the bus |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_op | output | 2 | 00 read, 01 read-for-ownership, 10 invalidate, 11 writeback |
| bus_addr | output | 6 | Transaction address |
| bus_wdata | output | 8 | Writeback data |
| bus_rdata | input | 8 | Fill data, valid in the grant cycle |
| snp_valid | input | 1 | Another node's transaction is on the bus |
| snp_op | input | 2 | Op code of the snooped transaction |
| snp_addr | input | 6 | Address of the snooped transaction |
| snp_supply | output | 1 | This node drives the data of the snooped block |
| snp_data | output | 8 | Supplied data |
| snp_cancel | output | 1 | Tells memory not to answer the snooped read |

## Verification
A corrupted state bit stays hidden until that line is touched again. A dirty bit that was lost shows up on the next eviction, which is missing its writeback, or on the next snooped read, which has no data supply. A shared bit that was lost lets a write complete locally instead of sending an invalidate, so ready rises a bus transaction early. Because of this, the bench compares every output against its reference on every cycle, and most stimuli revisit a line right after its state changes. Each fault then shows up within a few cycles of the access that exposes it.

// File: rtl/sic_pkg.sv
package sic_pkg;

    parameter int unsigned ADDR_W = 6;
    parameter int unsigned TAG_W  = 4;
    parameter int unsigned DATA_W = 8;

    localparam int unsigned IDX_W = ADDR_W - TAG_W;
    localparam int unsigned LINES = 1 << IDX_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [1:0] {
        OP_READ = 2'b00,
        OP_RFO  = 2'b01,
        OP_INV  = 2'b10,
        OP_WB   = 2'b11
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WB,
        ST_FETCH,
        ST_UPGR,
        ST_DONE
    } ctl_state_e;

    typedef struct packed {
        tag_t  tag;
        logic  valid;
        logic  dirty;
        logic  shared;
        data_t data;
    } line_t;

    function automatic tag_t tag_of(addr_t a);
        return a[ADDR_W-1:IDX_W];
    endfunction

    function automatic idx_t idx_of(addr_t a);
        return a[IDX_W-1:0];
    endfunction

    function automatic logic line_hit(line_t l, tag_t t);
        return l.valid && (l.tag == t);
    endfunction

endpackage

// File: rtl/sic_line_store.sv
module sic_line_store
    import sic_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cw_en,
    input  idx_t  cw_idx,
    input  line_t cw_line,
    input  logic  sw_en,
    input  idx_t  sw_idx,
    input  line_t sw_line,
    output line_t lines_o [LINES]
);

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            line_t q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (sw_en && (sw_idx == idx_t'(g))) begin
                    q <= sw_line;
                end else if (cw_en && (cw_idx == idx_t'(g))) begin
                    q <= cw_line;
                end
            end

            assign lines_o[g] = q;

            AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (!q.valid && !q.dirty && !q.shared)); // R2
        end
    endgenerate

    AST_NO_WRITE_CLASH: assert property (@(posedge clk) disable iff (rst) !(sw_en && cw_en && (sw_idx == cw_idx))); // R10

endmodule

// File: rtl/sic_snoop.sv
module sic_snoop
    import sic_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    snp_valid,
    input  bus_op_e snp_op,
    input  addr_t   snp_addr,
    input  line_t   lines [LINES],
    output logic    supply,
    output data_t   supply_data,
    output logic    sw_en,
    output idx_t    sw_idx,
    output line_t   sw_line
);

    line_t cur;
    logic  hit;
    logic  claims;

    always_comb begin
        sw_idx  = idx_of(snp_addr);
        cur     = lines[sw_idx];
        hit     = line_hit(cur, tag_of(snp_addr));
        claims  = (snp_op == OP_RFO) || (snp_op == OP_INV);
        supply  = snp_valid && hit && cur.dirty &&
                  ((snp_op == OP_READ) || (snp_op == OP_RFO));
        supply_data = cur.data;
        sw_en   = snp_valid && hit && (snp_op != OP_WB);
        sw_line = cur;
        if (claims) begin
            sw_line.valid  = 1'b0;
            sw_line.dirty  = 1'b0;
            sw_line.shared = 1'b0;
        end else begin
            sw_line.dirty  = 1'b0;
            sw_line.shared = 1'b1;
        end
    end

    idx_t last_idx;
    always_ff @(posedge clk) begin
        if (rst) last_idx <= '0;
        else     last_idx <= sw_idx;
    end

    AST_READ_SUPPLY_CLEANS: assert property (@(posedge clk) disable iff (rst) (supply && (snp_op == OP_READ)) |=> (!lines[last_idx].dirty && lines[last_idx].shared)); // R7
    AST_CLAIM_DROPS_LINE: assert property (@(posedge clk) disable iff (rst) (snp_valid && hit && claims) |=> !lines[last_idx].valid); // R8
    AST_WB_SNOOP_QUIET: assert property (@(posedge clk) disable iff (rst) (snp_valid && (snp_op == OP_WB)) |-> !supply); // R8

endmodule

// File: rtl/sic_ctrl.sv
module sic_ctrl
    import sic_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cpu_req,
    input  logic    cpu_we,
    input  addr_t   cpu_addr,
    input  data_t   cpu_wdata,
    output data_t   cpu_rdata,
    output logic    cpu_ready,
    output logic    bus_req,
    input  logic    bus_gnt,
    output bus_op_e bus_op,
    output addr_t   bus_addr,
    output data_t   bus_wdata,
    input  data_t   bus_rdata,
    input  logic    snp_valid,
    input  line_t   lines [LINES],
    output logic    cw_en,
    output idx_t    cw_idx,
    output line_t   cw_line
);

    ctl_state_e state, state_n;
    logic  q_we;
    addr_t q_addr;
    data_t q_wd;

    idx_t  in_idx;
    line_t in_line;
    logic  in_hit;
    idx_t  qi;
    tag_t  qt;
    line_t ql;
    logic  q_hit;
    logic  vict_dirty;
    logic  take;

    always_comb begin
        in_idx     = idx_of(cpu_addr);
        in_line    = lines[in_idx];
        in_hit     = line_hit(in_line, tag_of(cpu_addr));
        qi         = idx_of(q_addr);
        qt         = tag_of(q_addr);
        ql         = lines[qi];
        q_hit      = line_hit(ql, qt);
        vict_dirty = ql.valid && ql.dirty;
        take       = (state == ST_IDLE) && cpu_req && !snp_valid;

        state_n   = state;
        cw_en     = 1'b0;
        cw_idx    = qi;
        cw_line   = ql;
        bus_req   = 1'b0;
        bus_op    = OP_READ;
        bus_addr  = q_addr;
        bus_wdata = ql.data;
        cpu_ready = 1'b0;
        cpu_rdata = ql.data;

        unique case (state)
            ST_IDLE: begin
                cw_idx  = in_idx;
                cw_line = in_line;
                if (take) begin
                    if (in_hit && !cpu_we) begin
                        state_n = ST_DONE;
                    end else if (in_hit && !in_line.shared) begin
                        cw_en         = 1'b1;
                        cw_line.data  = cpu_wdata;
                        cw_line.dirty = 1'b1;
                        state_n       = ST_DONE;
                    end else if (in_hit) begin
                        state_n = ST_UPGR;
                    end else if (in_line.valid && in_line.dirty) begin
                        state_n = ST_WB;
                    end else begin
                        state_n = ST_FETCH;
                    end
                end
            end
            ST_WB: begin
                bus_op   = OP_WB;
                bus_addr = {ql.tag, qi};
                if (!vict_dirty) begin
                    state_n = ST_FETCH;
                end else begin
                    bus_req = 1'b1;
                    if (bus_gnt) begin
                        cw_en         = 1'b1;
                        cw_line.dirty = 1'b0;
                        state_n       = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                bus_req = 1'b1;
                bus_op  = q_we ? OP_RFO : OP_READ;
                if (bus_gnt) begin
                    cw_en          = 1'b1;
                    cw_line.tag    = qt;
                    cw_line.valid  = 1'b1;
                    cw_line.dirty  = q_we;
                    cw_line.shared = !q_we;
                    cw_line.data   = q_we ? q_wd : bus_rdata;
                    state_n        = ST_DONE;
                end
            end
            ST_UPGR: begin
                bus_op = OP_INV;
                if (!q_hit) begin
                    state_n = ST_FETCH;
                end else begin
                    bus_req = 1'b1;
                    if (bus_gnt) begin
                        cw_en          = 1'b1;
                        cw_line.data   = q_wd;
                        cw_line.dirty  = 1'b1;
                        cw_line.shared = 1'b0;
                        state_n        = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                cpu_ready = 1'b1;
                state_n   = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            q_we   <= 1'b0;
            q_addr <= '0;
            q_wd   <= '0;
        end else begin
            state <= state_n;
            if (take) begin
                q_we   <= cpu_we;
                q_addr <= cpu_addr;
                q_wd   <= cpu_wdata;
            end
        end
    end

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst) cpu_ready |=> !cpu_ready); // R10
    AST_READ_FILL_SHARED: assert property (@(posedge clk) disable iff (rst) ((state == ST_FETCH) && bus_gnt && !q_we) |=> (ql.valid && !ql.dirty && ql.shared)); // R3
    AST_WRITE_OWNS: assert property (@(posedge clk) disable iff (rst) (cpu_ready && q_we) |-> (q_hit && ql.dirty && !ql.shared)); // R4
    AST_WB_BEFORE_FETCH: assert property (@(posedge clk) disable iff (rst) (state == ST_FETCH) |-> !(ql.valid && ql.dirty && (ql.tag != qt))); // R6

endmodule

// File: rtl/snoop_inval_cache.sv
module snoop_inval_cache
    import sic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data,
    output logic              snp_cancel
);

    line_t   lines [LINES];
    logic    cw_en, sw_en;
    idx_t    cw_idx, sw_idx;
    line_t   cw_line, sw_line;
    bus_op_e op_out;
    bus_op_e op_in;

    assign op_in = bus_op_e'(snp_op);

    sic_line_store u_store (
        .clk     (clk),
        .rst     (rst),
        .cw_en   (cw_en),
        .cw_idx  (cw_idx),
        .cw_line (cw_line),
        .sw_en   (sw_en),
        .sw_idx  (sw_idx),
        .sw_line (sw_line),
        .lines_o (lines)
    );

    sic_snoop u_snoop (
        .clk         (clk),
        .rst         (rst),
        .snp_valid   (snp_valid),
        .snp_op      (op_in),
        .snp_addr    (snp_addr),
        .lines       (lines),
        .supply      (snp_supply),
        .supply_data (snp_data),
        .sw_en       (sw_en),
        .sw_idx      (sw_idx),
        .sw_line     (sw_line)
    );

    sic_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cpu_ready (cpu_ready),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .bus_op    (op_out),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .snp_valid (snp_valid),
        .lines     (lines),
        .cw_en     (cw_en),
        .cw_idx    (cw_idx),
        .cw_line   (cw_line)
    );

    assign bus_op     = op_out;
    assign snp_cancel = snp_supply;

    AST_CANCEL_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (rst) snp_cancel |-> (snp_valid && !snp_op[1])); // R7

endmodule

// File: tb/snoop_inval_cache_test.sv
module snoop_inval_cache_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0, we = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wd = '0;
    logic [7:0] cpu_rdata;
    logic       cpu_ready;
    logic       bus_req;
    logic       gnt = 1'b0;
    logic [1:0] bus_op;
    logic [5:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] rdata = '0;
    logic       snv = 1'b0;
    logic [1:0] sop = '0;
    logic [5:0] saddr = '0;
    logic       snp_supply, snp_cancel;
    logic [7:0] snp_data;

    always #10 clk = ~clk;

    snoop_inval_cache uut (
        .clk(clk), .rst(rst),
        .cpu_req(req), .cpu_we(we), .cpu_addr(addr), .cpu_wdata(wd),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .bus_req(bus_req), .bus_gnt(gnt), .bus_op(bus_op), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata),
        .snp_valid(snv), .snp_op(sop), .snp_addr(saddr),
        .snp_supply(snp_supply), .snp_data(snp_data), .snp_cancel(snp_cancel)
    );

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int wd_cnt = 0;
    int sched_cyc = -1;
    logic [1:0] sched_op = '0;
    logic [5:0] sched_addr = '0;
    int gnt_delay = 0;
    int wait_cnt = 0;
    logic req_seen = 1'b0;
    logic last_ready = 1'b0;
    logic [7:0] last_rdata = '0;
    string cur_req = "R2";

    // reference state
    logic [7:0] mem [64];
    logic [3:0] m_tag [4];
    logic       m_v [4], m_d [4], m_s [4];
    logic [7:0] m_dat [4];
    int         ph = 0;
    logic       q_we = 1'b0;
    logic [5:0] q_a = '0;
    logic [7:0] q_wd = '0;

    task automatic chk(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", cur_req, what, act, exp, cyc);
        end
    endtask

    task automatic compare();
        logic [1:0] qi, si;
        logic vict, qhit, shit, e_req, e_sup;
        int e_op;
        logic [5:0] e_addr;
        qi = q_a[1:0];
        vict = m_v[qi] && m_d[qi];
        qhit = m_v[qi] && (m_tag[qi] == q_a[5:2]);
        e_req = ((ph == 1) && vict) || (ph == 2) || ((ph == 3) && qhit);
        e_op = (ph == 1) ? 3 : (ph == 2) ? (q_we ? 1 : 0) : 2;
        e_addr = (ph == 1) ? {m_tag[qi], qi} : q_a;
        si = saddr[1:0];
        shit = m_v[si] && (m_tag[si] == saddr[5:2]);
        e_sup = snv && shit && m_d[si] && (sop == 2'd0 || sop == 2'd1);
        chk("cpu_ready", cpu_ready, ph == 4);
        chk("bus_req", bus_req, e_req);
        chk("snp_supply", snp_supply, e_sup);
        chk("snp_cancel", snp_cancel, e_sup);
        if (e_req) begin
            chk("bus_op", bus_op, e_op);
            chk("bus_addr", bus_addr, e_addr);
            if (e_op == 3) chk("bus_wdata", bus_wdata, m_dat[qi]);
        end
        if (ph == 4) chk("cpu_rdata", cpu_rdata, m_dat[qi]);
        if (e_sup) chk("snp_data", snp_data, m_dat[si]);
        req_seen = bus_req;
        last_ready = cpu_ready;
        if (cpu_ready) last_rdata = cpu_rdata;
    endtask

    task automatic model_update();
        logic [1:0] qi, si, i;
        logic vict, qhit, s_en, h;
        if (rst) begin
            for (int k = 0; k < 4; k++) begin
                m_tag[k] = '0; m_v[k] = 0; m_d[k] = 0; m_s[k] = 0; m_dat[k] = '0;
            end
            ph = 0; q_we = 0; q_a = '0; q_wd = '0;
            return;
        end
        qi = q_a[1:0];
        vict = m_v[qi] && m_d[qi];
        qhit = m_v[qi] && (m_tag[qi] == q_a[5:2]);
        si = saddr[1:0];
        s_en = snv && m_v[si] && (m_tag[si] == saddr[5:2]) && (sop != 2'd3);
        case (ph)
            0: if (req && !snv) begin
                q_we = we; q_a = addr; q_wd = wd;
                i = addr[1:0];
                h = m_v[i] && (m_tag[i] == addr[5:2]);
                if (h && !we) ph = 4;
                else if (h && !m_s[i]) begin m_dat[i] = wd; m_d[i] = 1; ph = 4; end
                else if (h) ph = 3;
                else if (m_v[i] && m_d[i]) ph = 1;
                else ph = 2;
            end
            1: if (!vict) ph = 2;
               else if (gnt) begin mem[{m_tag[qi], qi}] = m_dat[qi]; m_d[qi] = 0; ph = 2; end
            2: if (gnt) begin
                m_tag[qi] = q_a[5:2]; m_v[qi] = 1; m_d[qi] = q_we; m_s[qi] = !q_we;
                m_dat[qi] = q_we ? q_wd : rdata; ph = 4;
            end
            3: if (!qhit) ph = 2;
               else if (gnt) begin m_dat[qi] = q_wd; m_d[qi] = 1; m_s[qi] = 0; ph = 4; end
            default: ph = 0;
        endcase
        if (s_en) begin
            if (sop == 2'd0) begin m_d[si] = 0; m_s[si] = 1; end
            else begin m_v[si] = 0; m_d[si] = 0; m_s[si] = 0; end
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (cyc == sched_cyc) begin snv = 1; sop = sched_op; saddr = sched_addr; end
        #2;
        gnt = bus_req && !snv && (wait_cnt >= gnt_delay);
        rdata = mem[bus_addr];
        #2;
        compare();
        @(posedge clk);
        model_update();
        if (req_seen && !gnt) wait_cnt++; else wait_cnt = 0;
        cyc++;
        #1;
        snv = 0;
        gnt = 0;
    endtask

    task automatic access(logic w, logic [5:0] a, logic [7:0] d);
        req = 1; we = w; addr = a; wd = d;
        for (int n = 0; n < 40; n++) begin
            step();
            if (last_ready) break;
        end
        req = 0;
        step();
    endtask

    task automatic snoop(logic [1:0] op, logic [5:0] a);
        sched_cyc = cyc; sched_op = op; sched_addr = a;
        step();
        step();
    endtask

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 20000) begin
            fails++;
            $display("FAIL R10 watchdog actual=%0d expected<20000", wd_cnt);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 64; k++) mem[k] = 8'(k * 5 + 1);
        @(posedge clk);
        model_update();
        cur_req = "R2";
        step();
        step();
        rst = 0;
        step();

        cur_req = "R3"; gnt_delay = 2;
        access(0, 6'h2A, 8'h00);
        chk("read miss data", last_rdata, 8'hD3);

        cur_req = "R1";
        access(0, 6'h2A, 8'h00);
        chk("read hit data", last_rdata, 8'hD3);

        cur_req = "R3"; gnt_delay = 0;
        access(0, 6'h1A, 8'h00);
        chk("clean replace data", last_rdata, 8'h83);

        cur_req = "R4"; gnt_delay = 1;
        access(1, 6'h3C, 8'h55);
        chk("write miss data", last_rdata, 8'h55);

        cur_req = "R1";
        access(1, 6'h3C, 8'h66);
        chk("local write hit", last_rdata, 8'h66);

        cur_req = "R5"; gnt_delay = 2;
        access(1, 6'h1A, 8'h44);
        chk("shared write hit", last_rdata, 8'h44);

        cur_req = "R6";
        access(0, 6'h0C, 8'h00);
        chk("read after writeback", last_rdata, 8'h3D);
        access(0, 6'h3C, 8'h00);
        chk("written-back value", last_rdata, 8'h66);

        cur_req = "R7";
        snoop(2'd0, 6'h1A);
        snoop(2'd0, 6'h1A);
        snoop(2'd0, 6'h2A);

        cur_req = "R8"; gnt_delay = 0;
        access(1, 6'h05, 8'h11);
        snoop(2'd1, 6'h05);
        access(0, 6'h05, 8'h00);
        chk("refetch after claim", last_rdata, 8'h1A);
        snoop(2'd3, 6'h3C);
        access(0, 6'h3C, 8'h00);
        snoop(2'd2, 6'h3C);
        access(0, 6'h3C, 8'h00);
        chk("refetch after invalidate", last_rdata, 8'h66);

        cur_req = "R9"; gnt_delay = 4;
        access(0, 6'h2A, 8'h00);
        sched_cyc = cyc + 2; sched_op = 2'd1; sched_addr = 6'h2A;
        access(1, 6'h2A, 8'h77);
        chk("write after losing race", last_rdata, 8'h77);

        cur_req = "R10"; gnt_delay = 1;
        sched_cyc = cyc; sched_op = 2'd0; sched_addr = 6'h11;
        access(0, 6'h2A, 8'h00);
        chk("deferred request data", last_rdata, 8'h77);
        sched_cyc = cyc; sched_op = 2'd1; sched_addr = 6'h2A;
        access(0, 6'h2A, 8'h00);
        chk("request after lost line", last_rdata, 8'hD3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule